// File: doc/BRIEF.md
# Error-Compensated Fixed-Width Signed Booth Multiplier

This block multiplies two signed N-bit two's complement operands and returns only N bits: an estimate of the upper half of the 2N-bit product. It is purely combinational, with no clock and no state. A result is valid as soon as the operand inputs have settled. It fits datapaths such as filters and transforms, where the word width has to stay fixed from stage to stage.

The multiplier operand is recoded in radix 4. Each recoded digit selects a row made from the multiplicand. Partial-product bits that land in the lower N columns are never summed. Instead, two small population counts look at the two columns just below the cut. The upper group is column N-1 and the lower group is column N-2. Their weighted, rounded sum is injected as a carry-in value at the lowest kept column.

The kept rows, a folded sign-extension constant and the correction word pass through a chain of full-adder rows until a sum row and a carry row remain. A final carry-propagate addition produces the output.

Top module: `fxw_mul`

## Requirements
- R1: The multiplier operand `b_in`, with a 0 appended below bit 0, is split into N/2 overlapping 3-bit groups. Group i is (b[2i+1], b[2i], b[2i-1]) and has weight 4^i. The group maps to digit d_i = -2*b[2i+1] + b[2i] + b[2i-1], which lies in {-2,-1,0,+1,+2}.
- R2: Each group drives three select lines: a x1 select, a x2 select and a negate select. The x1 and x2 selects are never both high. The negate select is high exactly when d_i < 0.
- R3: A zero digit (group 000 or 111) contributes nothing to the product. When `b_in` is 0, the result is 0.
- R4: Row i carries the bits w_i = (d_i*a - neg_i) mod 2^N at columns 2i..2i+N-1. Its negate bit sits at column 2i. The truncated sum is T = sum over i of ((w_i mod 2^(N-2i)) + neg_i) * 4^i.
- R5: Let U be the number of ones in bit N-1-2i of w_i over all rows. Let D be the number of ones in bit N-2-2i of w_i over all rows, plus the top row's negate bit. The correction is K = floor((2U + D + 2) / 4).
- R6: For every operand pair, `prod_hi` equals ((a*b - T) / 2^N + K) mod 2^N.
- R7: For N = 16, the signed value of `prod_hi` differs from floor(a*b / 2^N) by at most 2.
- R8: The most negative operand times itself gives exactly 2^(N-2). For N = 16 this is 0x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | Multiplicand, signed two's complement |
| b_in | input | N | Multiplier, signed two's complement, Booth-recoded |
| prod_hi | output | N | Compensated estimate of the upper product half |

## Verification
The multiplier has no register, so every result is due in the same cycle its operands are applied. The bench drives a new operand pair just after a rising clock edge. It samples `prod_hi` at the following falling edge, half a period later, when the combinational path has settled.

At each of those falling edges, a behavioural model of the recoding, the truncated sum and the correction rule gives the exact expected word (R6). The exact product gives the error bound (R7). Directed pairs pin the zero digit, negative digits and the most negative square, where the correction supplies the final unit.

// File: rtl/fxw_pkg.sv
package fxw_pkg;

  // Select lines produced for one radix-4 digit.
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } booth_sel_t;

  // Upper-half image of the sign-extension constant: -(sum of 4^i) for N/2 rows.
  function automatic logic [63:0] sext_const(input int n);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < n / 2; i++) begin
      acc = acc + (64'd1 << (2 * i));
    end
    return (~acc) + 64'd1;
  endfunction

endpackage

// File: rtl/fxw_booth_enc.sv
module fxw_booth_enc
  import fxw_pkg::*;
(
  input  logic [2:0]  grp,
  output booth_sel_t  sel
);

  always_comb begin
    sel.one = grp[1] ^ grp[0];
    sel.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    sel.neg = grp[2] & ~(grp[1] & grp[0]);

    // R2
    sel_excl_chk: assert (!(sel.one && sel.two));
    // R2
    neg_live_chk: assert (!sel.neg || sel.one || sel.two);
  end

endmodule

// File: rtl/fxw_pp_row.sv
module fxw_pp_row
  import fxw_pkg::*;
#(
  parameter int N  = 16,
  parameter int LO = 0,
  localparam int RW = N - LO + 1
) (
  input  booth_sel_t      sel,
  input  logic [RW:0]     xs,
  output logic [RW-1:0]   bits
);

  always_comb begin
    for (int k = 0; k < RW; k++) begin
      bits[k] = ((sel.one & xs[k+1]) | (sel.two & xs[k])) ^ sel.neg;
    end
    // top position carries the inverted sign bit
    bits[RW-1] = ~bits[RW-1];

    // R3
    if (!sel.one && !sel.two) begin
      zero_row_chk: assert (bits == {1'b1, {(RW-1){1'b0}}});
    end
  end

endmodule

// File: rtl/fxw_popcount.sv
module fxw_popcount #(
  parameter int W  = 8,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v,
  output logic [OW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int k = 0; k < W; k++) begin
      cnt = cnt + OW'(v[k]);
    end
  end

endmodule

// File: rtl/fxw_comp.sv
module fxw_comp #(
  parameter int N    = 16,
  parameter int ROWS = N / 2,
  localparam int CW   = $clog2(ROWS + 2),
  localparam int CMAX = (3 * ROWS + 3) / 4
) (
  input  logic [ROWS-1:0] up_bits,
  input  logic [ROWS:0]   dn_bits,
  output logic [N-1:0]    corr
);

  logic [CW-1:0] up_cnt;
  logic [CW-1:0] dn_cnt;
  logic [CW+1:0] acc;

  fxw_popcount #(.W(ROWS),     .OW(CW)) u_up (.v(up_bits), .cnt(up_cnt));
  fxw_popcount #(.W(ROWS + 1), .OW(CW)) u_dn (.v(dn_bits), .cnt(dn_cnt));

  always_comb begin
    acc  = ({2'b00, up_cnt} << 1) + {2'b00, dn_cnt} + (CW+2)'(2);
    corr = N'(acc >> 2);

    // R5
    up_count_chk: assert (int'(up_cnt) <= ROWS);
    // R5
    corr_range_chk: assert (int'(corr) <= CMAX);
  end

endmodule

// File: rtl/fxw_csa_chain.sv
module fxw_csa_chain #(
  parameter int N = 16,
  parameter int M = 10
) (
  input  logic [M-1:0][N-1:0] ops,
  output logic [N-1:0]        sum_row,
  output logic [N-1:0]        car_row
);

  logic [N-1:0] s_st [1:M-1];
  logic [N-1:0] c_st [1:M-1];

  assign s_st[1] = ops[0];
  assign c_st[1] = ops[1];

  for (genvar k = 2; k < M; k++) begin : g_fa_row
    logic [N-1:0] maj;
    assign s_st[k] = s_st[k-1] ^ c_st[k-1] ^ ops[k];
    assign maj     = (s_st[k-1] & c_st[k-1]) | (s_st[k-1] & ops[k]) | (c_st[k-1] & ops[k]);
    assign c_st[k] = maj << 1;
  end

  assign sum_row = s_st[M-1];
  assign car_row = c_st[M-1];

endmodule

// File: rtl/fxw_mul.sv
module fxw_mul
  import fxw_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic [N-1:0] prod_hi
);

  localparam int ROWS = N / 2;
  localparam int NOPS = ROWS + 2;
  localparam logic [63:0]  KFULL = sext_const(N);
  localparam logic [N-1:0] KHI   = KFULL[N-1:0];

  logic [N+1:0] xw;
  logic [N:0]   yw;
  assign xw = {a_in[N-1], a_in, 1'b0};
  assign yw = {b_in, 1'b0};

  booth_sel_t   sel  [ROWS];
  logic [N-1:0] krow [ROWS];
  logic         up_b [ROWS];
  logic         dn_b [ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int LO = N - 2 - 2 * i;
    logic [2*i+2:0] r;

    fxw_booth_enc u_enc (
      .grp (yw[2*i+2:2*i]),
      .sel (sel[i])
    );

    fxw_pp_row #(.N(N), .LO(LO)) u_pp (
      .sel  (sel[i]),
      .xs   (xw[N+1:LO]),
      .bits (r)
    );

    assign dn_b[i] = r[0];
    assign up_b[i] = r[1];
    if (i < ROWS - 1) begin : g_pad
      assign krow[i] = {{(N-2*i-1){1'b0}}, r[2*i+2:2]};
    end else begin : g_top
      assign krow[i] = {1'b0, r[2*i+2:2]};
    end
  end

  logic [ROWS-1:0] up_vec;
  logic [ROWS:0]   dn_vec;
  logic [N-1:0]    corr;

  always_comb begin
    for (int i = 0; i < ROWS; i++) begin
      up_vec[i] = up_b[i];
      dn_vec[i] = dn_b[i];
    end
    dn_vec[ROWS] = sel[ROWS-1].neg;
  end

  fxw_comp #(.N(N), .ROWS(ROWS)) u_comp (
    .up_bits (up_vec),
    .dn_bits (dn_vec),
    .corr    (corr)
  );

  logic [NOPS-1:0][N-1:0] ops;
  always_comb begin
    for (int i = 0; i < ROWS; i++) begin
      ops[i] = krow[i];
    end
    ops[ROWS]     = KHI;
    ops[ROWS + 1] = corr;
  end

  logic [N-1:0] sum_row;
  logic [N-1:0] car_row;

  fxw_csa_chain #(.N(N), .M(NOPS)) u_csa (
    .ops     (ops),
    .sum_row (sum_row),
    .car_row (car_row)
  );

  assign prod_hi = sum_row + car_row;

endmodule

// File: tb/sim_fxw_mul.sv
module sim_fxw_mul;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst;
  logic [N-1:0] a;
  logic [N-1:0] b;
  wire  [N-1:0] p;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fxw_mul #(.N(N)) u0 (.a_in(a), .b_in(b), .prod_hi(p));

  // Behavioural model of the requirement formulas (R1, R4, R5, R6).
  function automatic longint ref_out(input logic [N-1:0] xa, input logic [N-1:0] yb);
    longint x, y, mask, t, v, w, res;
    int u, d, k;
    logic [N:0] yw;
    x = longint'($signed(xa));
    y = longint'($signed(yb));
    yw = {yb, 1'b0};
    mask = (64'sd1 <<< N) - 1;
    t = 0; u = 0; d = 0;
    for (int i = 0; i < N / 2; i++) begin
      int dg, ng;
      dg = -2 * int'(yw[2*i+2]) + int'(yw[2*i+1]) + int'(yw[2*i]);
      ng = (dg < 0) ? 1 : 0;
      v = longint'(dg) * x - longint'(ng);
      w = v & mask;
      t = t + (((w & ((64'sd1 <<< (N - 2*i)) - 1)) + longint'(ng)) <<< (2*i));
      u = u + int'((w >>> (N - 1 - 2*i)) & 1);
      d = d + int'((w >>> (N - 2 - 2*i)) & 1);
      if (i == N / 2 - 1) d = d + ng;
    end
    k = (2 * u + d + 2) >> 2;
    res = ((x * y - t) >>> N) + longint'(k);
    return res & mask;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  // R6 exact word, R7 error bound against the exact product
  task automatic check_model();
    longint ex, err;
    int ok;
    chk("R6", longint'(p), ref_out(a, b));
    ex  = (longint'($signed(a)) * longint'($signed(b))) >>> N;
    err = longint'($signed(p)) - ex;
    ok  = (err <= 2 && err >= -2) ? 1 : 0;
    chk("R7", longint'(ok), 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] corners [8];
    rst = 1'b1;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R8 and R5: most negative squared; the last unit comes from the correction
    apply(16'h8000, 16'h8000);
    chk("R8", longint'(p), 64'h4000);
    chk("R5", longint'(p), 64'h4000);
    // R3: zero multiplier, all digits zero
    apply(16'h1234, 16'h0000);
    chk("R3", longint'(p), 0);
    apply(16'h8000, 16'h0000);
    chk("R3", longint'(p), 0);
    // R1: single +1 digit in group 1
    apply(16'h4000, 16'h0004);
    chk("R1", longint'(p), 1);
    // R4 and R2: single -1 digit, inverted row plus negate bit
    apply(16'h4000, 16'hFFFC);
    chk("R4", longint'(p), 64'hFFFF);
    chk("R2", longint'(p), ref_out(a, b));
    // R3: multiplicand zero with multiplier -1
    apply(16'h0000, 16'hFFFF);
    chk("R3", longint'(p), 0);

    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'hFFFF;
    corners[3] = 16'h7FFF; corners[4] = 16'h8000; corners[5] = 16'h5555;
    corners[6] = 16'hAAAA; corners[7] = 16'h8001;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(corners[i], corners[j]);
        check_model();
      end
    end

    for (int n = 0; n < 3000; n++) begin
      apply(N'($urandom), N'($urandom));
      check_model();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule